// File: doc/BRIEF.md
# Set-associative tag controller with victim buffer

This block keeps the tags, valid bits, dirty bits and recency state of a write-back, write-allocate first-level cache. It also keeps the same state for a small fully associative victim buffer. The buffer holds only blocks pushed out of the main array. Requests arrive one at a time on a valid/ready port. Each carries a 32-bit byte address and a read/write flag. The block classifies every request into one of four outcomes and updates its state to match. It reports the outcome through a one-cycle completion pulse. The data arrays are held elsewhere. The next memory level is reached through a request/acknowledge port that carries block-aligned read (fill) and write-back transactions.

A miss in the main array goes one of three ways. If the set has a free way, that way is filled. If the miss hits the victim buffer, the two tags are swapped and the dirty bits are exchanged, with no traffic to the next level. Otherwise the least recently used block is demoted into the buffer. A dirty buffer entry that has to make room is written back first. Nine statistics counters track the traffic.

Top module: `cvb_ctrl`

## Requirements
- R1: The byte address splits into three fields. The low log2(BLOCK_BYTES) bits are the block offset and never affect matching. The next log2(NUM_SETS) bits select the set. The remaining upper bits are the tag, so equal tags in different sets are different blocks.
- R2: On a hit, outcome_o is 0 and done_o pulses in the cycle after acceptance. There is no next-level access. The way becomes most recent, and a write also marks it dirty.
- R3: A miss in a set that has an invalid way fills the lowest-numbered invalid way. It issues one read at the block-aligned address (offset bits zero) and leaves the victim buffer unchanged. outcome_o is 1.
- R4: A miss that hits the victim buffer in a full set swaps the tag of the least recently used way with the matching buffer entry. Each side takes the other's dirty bit, and a write additionally sets the dirty bit of the main-array way. There is no next-level access, and outcome_o is 2.
- R5: A miss that also misses the buffer in a full set moves the least recently used way, with its dirty bit, into the buffer. If the buffer slot being replaced holds a dirty block, that block is first written back (mem_we_o=1) at its own block address. Only then is the requested block read. outcome_o is 3.
- R6: Recency uses a saturating age per way and per buffer entry. The entry touched is set to zero, and every other valid entry is incremented. The victim is the valid entry with the largest age, with the lowest index winning a tie.
- R7: The buffer has VB_BYTES/BLOCK_BYTES entries, and any entry can hold any block. When space is needed, the lowest-numbered invalid entry is used; if there is none, the entry picked by R6 is used.
- R8: A block is never present in both the main array and the buffer. The buffer never holds two copies of one block.
- R9: req_ready_o is low while a next-level transaction is outstanding. mem_req_o, mem_we_o and mem_addr_o hold steady until mem_ack_i.
- R10: The counters for reads, writes, read hits, write hits, read misses, write misses, swaps, write-backs and next-level transfers each count the matching events. Every fill and every write-back is one transfer.
- R11: After reset all valid and dirty bits are clear, all counters are zero, req_ready_o is high, and done_o and mem_req_o are low.
- R12: For a miss that fills, done_o pulses in the cycle after the read acknowledge. A swap completes like a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address |
| done_o | output | 1 | One-cycle completion pulse |
| outcome_o | output | 2 | 0 hit, 1 fill free way, 2 buffer swap, 3 evict; valid with done_o |
| mem_req_o | output | 1 | Next-level transaction pending |
| mem_we_o | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr_o | output | 32 | Block-aligned next-level address |
| mem_ack_i | input | 1 | Next level completes the transaction |
| cnt_reads_o | output | 16 | Read requests |
| cnt_writes_o | output | 16 | Write requests |
| cnt_rd_hits_o | output | 16 | Read hits |
| cnt_wr_hits_o | output | 16 | Write hits |
| cnt_rd_miss_o | output | 16 | Read misses |
| cnt_wr_miss_o | output | 16 | Write misses |
| cnt_swaps_o | output | 16 | Buffer swaps |
| cnt_wbacks_o | output | 16 | Write-backs |
| cnt_xfers_o | output | 16 | Next-level transfers |

## Verification
Two things land in one cycle when a write request hits the victim buffer. The swap copies the old way's dirty bit into the buffer, and the request sets the new way's dirty bit. The bench provokes this by writing a block that sits in the buffer while the least recently used way is clean. It then forces evictions until that block and the one swapped back are pushed out of the buffer. Each must leave through a write-back at its own address, and the clean blocks must leave without one.

// File: rtl/cvb_pkg.sv
package cvb_pkg;
  typedef enum logic [1:0] {
    OUT_HIT   = 2'd0,
    OUT_FILL  = 2'd1,
    OUT_SWAP  = 2'd2,
    OUT_EVICT = 2'd3
  } outcome_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FETCH = 2'd2
  } state_e;

  localparam int NUM_STATS = 9;
  localparam int SI_RD     = 0;
  localparam int SI_WR     = 1;
  localparam int SI_RDHIT  = 2;
  localparam int SI_WRHIT  = 3;
  localparam int SI_RDMISS = 4;
  localparam int SI_WRMISS = 5;
  localparam int SI_SWAP   = 6;
  localparam int SI_WB     = 7;
  localparam int SI_XFER   = 8;
endpackage

// File: rtl/cvb_first_free.sv
module cvb_first_free #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  valid_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = ~&valid_i;
endmodule

// File: rtl/cvb_oldest.sv
module cvb_oldest #(
  parameter int N     = 2,
  parameter int AGE_W = 2,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][AGE_W-1:0] age_i,
  output logic [IW-1:0]           idx_o
);
  logic             found;
  logic [AGE_W-1:0] best;

  // strict compare keeps the lowest index on a tie
  always_comb begin
    idx_o = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && (!found || age_i[i] > best)) begin
        found = 1'b1;
        best  = age_i[i];
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cvb_stats.sv
module cvb_stats #(
  parameter int N     = 9,
  parameter int CNT_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              inc_i,
  output logic [N-1:0][CNT_W-1:0]   cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_o[g] <= '0;
      else if (inc_i[g]) cnt_o[g] <= cnt_o[g] + CNT_W'(1);
    end

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_i[g] |=> cnt_o[g] == $past(cnt_o[g]) + CNT_W'(1)); // R10
    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !inc_i[g] |=> $stable(cnt_o[g])); // R10
  end
endmodule

// File: rtl/cvb_ctrl.sv
module cvb_ctrl
  import cvb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 16,
  parameter int NUM_SETS    = 2,
  parameter int NUM_WAYS    = 2,
  parameter int VB_BYTES    = 32,
  parameter int CNT_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              done_o,
  output logic [1:0]        outcome_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  output logic [CNT_W-1:0]  cnt_reads_o,
  output logic [CNT_W-1:0]  cnt_writes_o,
  output logic [CNT_W-1:0]  cnt_rd_hits_o,
  output logic [CNT_W-1:0]  cnt_wr_hits_o,
  output logic [CNT_W-1:0]  cnt_rd_miss_o,
  output logic [CNT_W-1:0]  cnt_wr_miss_o,
  output logic [CNT_W-1:0]  cnt_swaps_o,
  output logic [CNT_W-1:0]  cnt_wbacks_o,
  output logic [CNT_W-1:0]  cnt_xfers_o
);
  localparam int OFF_W   = $clog2(BLOCK_BYTES);
  localparam int SET_W   = $clog2(NUM_SETS);
  localparam int TAG_W   = ADDR_W - OFF_W - SET_W;
  localparam int BLK_W   = ADDR_W - OFF_W;
  localparam int VB_N    = VB_BYTES / BLOCK_BYTES;
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int VBI_W   = (VB_N > 1) ? $clog2(VB_N) : 1;
  localparam int MAX_N   = (NUM_WAYS > VB_N) ? NUM_WAYS : VB_N;
  localparam int AGE_W   = $clog2(MAX_N) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  // main array state
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0] l1_tag_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][AGE_W-1:0] l1_age_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0]            l1_val_q, l1_dirty_q;
  // victim buffer state
  logic [VB_N-1:0][BLK_W-1:0] vb_blk_q;
  logic [VB_N-1:0][AGE_W-1:0] vb_age_q;
  logic [VB_N-1:0]            vb_val_q, vb_dirty_q;

  state_e   st_q;
  outcome_e outcome_q;
  logic     done_q;
  logic              r_write;
  logic [SET_W-1:0]  r_set;
  logic [TAG_W-1:0]  r_tag;
  logic [WAY_W-1:0]  r_way;
  logic [VBI_W-1:0]  r_vbe;
  logic [BLK_W-1:0]  r_wb_blk;

  // lookup
  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  logic [BLK_W-1:0] req_blk;
  logic             unused_off;
  assign req_set    = req_addr_i[OFF_W +: SET_W];
  assign req_tag    = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_blk    = req_addr_i[ADDR_W-1 -: BLK_W];
  assign unused_off = ^req_addr_i[OFF_W-1:0];

  logic [NUM_WAYS-1:0] l1_hit_vec;
  logic [VB_N-1:0]     vb_hit_vec;
  logic [WAY_W-1:0]    hit_way, free_way, lru_way;
  logic [VBI_W-1:0]    vb_hit_e, vb_free_e, vb_old_e, vb_vict;
  logic                free_found, vb_free_found;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      l1_hit_vec[w] = l1_val_q[req_set][w] && (l1_tag_q[req_set][w] == req_tag);
      if (l1_hit_vec[w]) hit_way = WAY_W'(w);
    end
    vb_hit_e = '0;
    for (int e = 0; e < VB_N; e++) begin
      vb_hit_vec[e] = vb_val_q[e] && (vb_blk_q[e] == req_blk);
      if (vb_hit_vec[e]) vb_hit_e = VBI_W'(e);
    end
  end

  cvb_first_free #(.N(NUM_WAYS)) u_l1_free (
    .valid_i(l1_val_q[req_set]), .found_o(free_found), .idx_o(free_way));
  cvb_oldest #(.N(NUM_WAYS), .AGE_W(AGE_W)) u_l1_old (
    .valid_i(l1_val_q[req_set]), .age_i(l1_age_q[req_set]), .idx_o(lru_way));
  cvb_first_free #(.N(VB_N)) u_vb_free (
    .valid_i(vb_val_q), .found_o(vb_free_found), .idx_o(vb_free_e));
  cvb_oldest #(.N(VB_N), .AGE_W(AGE_W)) u_vb_old (
    .valid_i(vb_val_q), .age_i(vb_age_q), .idx_o(vb_old_e));

  assign vb_vict = vb_free_found ? vb_free_e : vb_old_e;

  logic fire, is_hit, is_free, is_swap, is_evict, need_wb;
  assign fire     = req_valid_i && (st_q == ST_IDLE);
  assign is_hit   = |l1_hit_vec;
  assign is_free  = !is_hit && free_found;
  assign is_swap  = !is_hit && !free_found && |vb_hit_vec;
  assign is_evict = !is_hit && !free_found && !(|vb_hit_vec);
  assign need_wb  = vb_val_q[vb_vict] && vb_dirty_q[vb_vict];

  // demotion of the main-array victim into the buffer
  logic             do_move, fill_done, wb_done;
  logic [VBI_W-1:0] mv_e;
  logic [SET_W-1:0] mv_set;
  logic [WAY_W-1:0] mv_way;
  assign wb_done   = (st_q == ST_WBACK) && mem_ack_i;
  assign fill_done = (st_q == ST_FETCH) && mem_ack_i;
  assign do_move   = (fire && is_evict && !need_wb) || wb_done;
  assign mv_e      = (st_q == ST_IDLE) ? vb_vict : r_vbe;
  assign mv_set    = (st_q == ST_IDLE) ? req_set : r_set;
  assign mv_way    = (st_q == ST_IDLE) ? lru_way : r_way;

  // recency touch points
  logic             l1_touch, vb_touch;
  logic [SET_W-1:0] t_set;
  logic [WAY_W-1:0] t_way;
  logic [VBI_W-1:0] t_e;
  always_comb begin
    l1_touch = 1'b0;
    t_set    = req_set;
    t_way    = hit_way;
    if (fire && is_hit) l1_touch = 1'b1;
    if (fire && is_swap) begin
      l1_touch = 1'b1;
      t_way    = lru_way;
    end
    if (fill_done) begin
      l1_touch = 1'b1;
      t_set    = r_set;
      t_way    = r_way;
    end
    vb_touch = (fire && is_swap) || do_move;
    t_e      = (fire && is_swap) ? vb_hit_e : mv_e;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_tag_q   <= '0;
      l1_age_q   <= '0;
      l1_val_q   <= '0;
      l1_dirty_q <= '0;
    end else begin
      if (do_move) l1_val_q[mv_set][mv_way] <= 1'b0;
      if (fire && is_hit && req_write_i) l1_dirty_q[req_set][hit_way] <= 1'b1;
      if (fire && is_swap) begin
        l1_tag_q[req_set][lru_way]   <= req_tag;
        l1_dirty_q[req_set][lru_way] <= vb_dirty_q[vb_hit_e] | req_write_i;
      end
      if (fill_done) begin
        l1_tag_q[r_set][r_way]   <= r_tag;
        l1_val_q[r_set][r_way]   <= 1'b1;
        l1_dirty_q[r_set][r_way] <= r_write;
      end
      if (l1_touch) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (WAY_W'(w) == t_way) l1_age_q[t_set][w] <= '0;
          else if (l1_val_q[t_set][w] && l1_age_q[t_set][w] != AGE_MAX)
            l1_age_q[t_set][w] <= l1_age_q[t_set][w] + AGE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vb_blk_q   <= '0;
      vb_age_q   <= '0;
      vb_val_q   <= '0;
      vb_dirty_q <= '0;
    end else begin
      if (fire && is_swap) begin
        vb_blk_q[vb_hit_e]   <= {l1_tag_q[req_set][lru_way], req_set};
        vb_dirty_q[vb_hit_e] <= l1_dirty_q[req_set][lru_way];
      end
      if (do_move) begin
        vb_blk_q[mv_e]   <= {l1_tag_q[mv_set][mv_way], mv_set};
        vb_val_q[mv_e]   <= 1'b1;
        vb_dirty_q[mv_e] <= l1_dirty_q[mv_set][mv_way];
      end
      if (vb_touch) begin
        for (int e = 0; e < VB_N; e++) begin
          if (VBI_W'(e) == t_e) vb_age_q[e] <= '0;
          else if (vb_val_q[e] && vb_age_q[e] != AGE_MAX)
            vb_age_q[e] <= vb_age_q[e] + AGE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      outcome_q <= OUT_HIT;
      done_q    <= 1'b0;
      r_write   <= 1'b0;
      r_set     <= '0;
      r_tag     <= '0;
      r_way     <= '0;
      r_vbe     <= '0;
      r_wb_blk  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (fire) begin
          r_write  <= req_write_i;
          r_set    <= req_set;
          r_tag    <= req_tag;
          r_way    <= is_free ? free_way : lru_way;
          r_vbe    <= vb_vict;
          r_wb_blk <= vb_blk_q[vb_vict];
          if (is_hit) begin
            outcome_q <= OUT_HIT;
            done_q    <= 1'b1;
          end else if (is_free) begin
            outcome_q <= OUT_FILL;
            st_q      <= ST_FETCH;
          end else if (is_swap) begin
            outcome_q <= OUT_SWAP;
            done_q    <= 1'b1;
          end else begin
            outcome_q <= OUT_EVICT;
            st_q      <= need_wb ? ST_WBACK : ST_FETCH;
          end
        end
        ST_WBACK: if (mem_ack_i) st_q <= ST_FETCH;
        ST_FETCH: if (mem_ack_i) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign done_o      = done_q;
  assign outcome_o   = outcome_q;
  assign mem_req_o   = (st_q != ST_IDLE);
  assign mem_we_o    = (st_q == ST_WBACK);
  assign mem_addr_o  = (st_q == ST_WBACK) ? {r_wb_blk, {OFF_W{1'b0}}}
                                          : {r_tag, r_set, {OFF_W{1'b0}}};

  logic [NUM_STATS-1:0]            inc;
  logic [NUM_STATS-1:0][CNT_W-1:0] cnt;
  always_comb begin
    inc            = '0;
    inc[SI_RD]     = fire && !req_write_i;
    inc[SI_WR]     = fire && req_write_i;
    inc[SI_RDHIT]  = fire && is_hit && !req_write_i;
    inc[SI_WRHIT]  = fire && is_hit && req_write_i;
    inc[SI_RDMISS] = fire && !is_hit && !req_write_i;
    inc[SI_WRMISS] = fire && !is_hit && req_write_i;
    inc[SI_SWAP]   = fire && is_swap;
    inc[SI_WB]     = wb_done;
    inc[SI_XFER]   = mem_req_o && mem_ack_i;
  end

  cvb_stats #(.N(NUM_STATS), .CNT_W(CNT_W)) u_stats (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc), .cnt_o(cnt));

  assign cnt_reads_o   = cnt[SI_RD];
  assign cnt_writes_o  = cnt[SI_WR];
  assign cnt_rd_hits_o = cnt[SI_RDHIT];
  assign cnt_wr_hits_o = cnt[SI_WRHIT];
  assign cnt_rd_miss_o = cnt[SI_RDMISS];
  assign cnt_wr_miss_o = cnt[SI_WRMISS];
  assign cnt_swaps_o   = cnt[SI_SWAP];
  assign cnt_wbacks_o  = cnt[SI_WB];
  assign cnt_xfers_o   = cnt[SI_XFER];

  AST_L1_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(l1_hit_vec)); // R2
  AST_VB_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vb_hit_vec)); // R8
  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !(is_hit && |vb_hit_vec)); // R8
  AST_HIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && is_hit) |=> done_o && outcome_o == OUT_HIT && !mem_req_o); // R2
  AST_SWAP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && is_swap) |=> done_o && outcome_o == OUT_SWAP && !mem_req_o); // R4
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> !req_ready_o); // R9
  AST_WB_BEFORE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_ack_i) |=> mem_req_o && !mem_we_o); // R5
  AST_FILL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> done_o && !req_ready_o == 1'b0
      && (outcome_o == OUT_FILL || outcome_o == OUT_EVICT)); // R12
  AST_FREE_FILL_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[OFF_W-1:0] == '0); // R1
endmodule

// File: tb/cvb_ctrl_tb.sv
module cvb_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        mem_ack = 1'b0;
  logic        req_ready, done, mem_req, mem_we;
  logic [1:0]  outcome;
  logic [31:0] mem_addr;
  logic [15:0] c_rd, c_wr, c_rdh, c_wrh, c_rdm, c_wrm, c_sw, c_wb, c_xf;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  cvb_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr),
    .done_o(done), .outcome_o(outcome),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .cnt_reads_o(c_rd), .cnt_writes_o(c_wr), .cnt_rd_hits_o(c_rdh), .cnt_wr_hits_o(c_wrh),
    .cnt_rd_miss_o(c_rdm), .cnt_wr_miss_o(c_wrm), .cnt_swaps_o(c_sw),
    .cnt_wbacks_o(c_wb), .cnt_xfers_o(c_xf));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ad(input int tag, input int set, input int off);
    return {27'(tag), 1'(set), 4'(off)};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    chk(!done && !mem_req, "R11", "done/mem_req after reset", {done, mem_req}, 0);
    chk((c_rd | c_wr | c_rdh | c_wrh | c_rdm | c_wrm | c_sw | c_wb | c_xf) == 0,
        "R11", "counters after reset", c_rd | c_wr | c_xf, 0);
  endtask

  // one request, servicing the next level; checks outcome, traffic and timing
  task automatic access(input bit we, input logic [31:0] a, input int exp_out,
                        input bit exp_wb, input logic [31:0] wb_a,
                        input bit exp_rd, input logic [31:0] rd_a, input string req);
    int n_rd = 0, n_wr = 0, c_done = -1;
    bit order_ok = 1'b1, fill_seen = 1'b0;
    logic [31:0] got_rd = '0, got_wr = '0;
    chk(req_ready == 1'b1, "R9", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = we; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (done) begin c_done = c; break; end
      if (mem_req) begin
        logic [31:0] a0;
        logic w0;
        a0 = mem_addr; w0 = mem_we;
        chk(!req_ready, "R9", "ready low while pending", req_ready, 0);
        @(negedge clk);
        chk(mem_req && mem_addr == a0 && mem_we == w0, "R9", "request held",
            mem_addr, a0);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        if (w0) begin
          n_wr++; got_wr = a0;
          if (fill_seen) order_ok = 1'b0;
        end else begin
          n_rd++; got_rd = a0; fill_seen = 1'b1;
          chk(done == 1'b1, "R12", "done right after read ack", done, 1);
        end
      end else @(negedge clk);
    end
    chk(c_done >= 0, req, "request completed", c_done, 0);
    chk(outcome == 2'(exp_out), req, "outcome", outcome, exp_out);
    chk(n_wr == int'(exp_wb), "R5", "write-back count", n_wr, exp_wb);
    if (exp_wb) chk(got_wr == wb_a, "R5", "write-back address", got_wr, wb_a);
    chk(n_rd == int'(exp_rd), req, "fill count", n_rd, exp_rd);
    if (exp_rd) chk(got_rd == rd_a, req, "fill address", got_rd, rd_a);
    chk(order_ok, "R5", "write-back precedes fill", order_ok, 1);
    if (!exp_rd) chk(c_done == 0, "R12", "hit/swap completes next cycle", c_done, 0);
  endtask

  task automatic t_fill_and_hit();
    access(0, ad(1,0,8), 1, 0, 0, 1, ad(1,0,0), "R3");   // A fills way 0
    access(0, ad(1,0,4), 0, 0, 0, 0, 0, "R1");            // same block, other offset
    access(1, ad(1,0,0), 0, 0, 0, 0, 0, "R2");            // write hit -> A dirty
    access(0, ad(2,0,0), 1, 0, 0, 1, ad(2,0,0), "R3");   // B fills way 1
    access(0, ad(1,0,12), 0, 0, 0, 0, 0, "R2");           // A most recent, B oldest
  endtask

  task automatic t_evict();
    access(0, ad(3,0,0), 3, 0, 0, 1, ad(3,0,0), "R6");   // B clean -> buffer
    access(0, ad(4,0,0), 3, 0, 0, 1, ad(4,0,0), "R7");   // A dirty -> free slot
  endtask

  task automatic t_swap();
    access(1, ad(2,0,0), 2, 0, 0, 0, 0, "R4");            // write B from buffer, C out
    access(0, ad(1,0,0), 2, 0, 0, 0, 0, "R8");            // A from buffer, D out
  endtask

  task automatic t_writeback();
    access(0, ad(5,0,0), 3, 0, 0, 1, ad(5,0,0), "R7");   // B dirty in, C clean out
    access(0, ad(6,0,0), 3, 0, 0, 1, ad(6,0,0), "R6");   // A dirty in, D clean out
    access(0, ad(7,0,0), 3, 1, ad(2,0,0), 1, ad(7,0,0), "R5");  // B written back
    access(0, ad(8,0,0), 3, 1, ad(1,0,0), 1, ad(8,0,0), "R4");  // A dirty survived swaps
  endtask

  task automatic t_index();
    access(0, ad(7,1,0), 1, 0, 0, 1, ad(7,1,0), "R1");   // same tag, other set
  endtask

  task automatic t_counters();
    chk(c_rd == 12, "R10", "reads", c_rd, 12);
    chk(c_wr == 2, "R10", "writes", c_wr, 2);
    chk(c_rdh == 2, "R10", "read hits", c_rdh, 2);
    chk(c_wrh == 1, "R10", "write hits", c_wrh, 1);
    chk(c_rdm == 10, "R10", "read misses", c_rdm, 10);
    chk(c_wrm == 1, "R10", "write misses", c_wrm, 1);
    chk(c_sw == 2, "R10", "swaps", c_sw, 2);
    chk(c_wb == 2, "R10", "write-backs", c_wb, 2);
    chk(c_xf == 11, "R10", "transfers", c_xf, 11);
  endtask

  task automatic t_reset_clears();
    do_reset();
    access(0, ad(8,0,0), 1, 0, 0, 1, ad(8,0,0), "R11");  // was resident, now invalid
  endtask

  initial begin
    do_reset();
    t_fill_and_hit();
    t_evict();
    t_swap();
    t_writeback();
    t_index();
    t_counters();
    t_reset_clears();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule